// File: doc/BRIEF.md
# Host/Adapter Attention and Interrupt Register Block

This block holds the four 32-bit registers through which a host and a host adapter signal each other. Internal logic (the command rings, the mailbox, the link and the error detector) raises one-cycle event pulses. Each pulse latches a bit in the host-bound attention register. Each of these bits has its own interrupt enable in the control register, and the block drives one registered interrupt line from the enabled bits. A bit whose enable is off is still latched, so the host can poll it. The host clears attention bits by writing ones to them.

In the other direction, the host writes ones into the chip-bound attention register to ask the adapter to process a ring or a mailbox command. The block presents each request as a level. It also gives a one-cycle pulse when a request newly appears. Internal logic retires a request with a one-cycle acknowledge pulse. The status register shows whether the chipset and the mailbox are ready, together with a set of error flags. The control register also carries a self-clearing initialise command. This command wipes both attention registers and holds chipset-ready low for a fixed number of cycles.

Top module: `adapter_attn_regs`

## Requirements
- R1: The register select is host_addr_i: 0 is control, 1 is status, 2 is host attention, 3 is chip attention. A read strobe returns the selected register on host_rdata_o after that clock edge and holds it until the next read. Bits not defined below read as zero.
- R2: Host-attention bit positions are: rings in bits 0..3, mailbox in bit 4, link in bit 5, error in bit 6. An event pulse on a source sets its bit at that clock edge.
- R3: Writing to the host-attention register clears each bit written as 1 and leaves the bits written as 0 alone. An event on a bit in the same cycle as its clear leaves the bit set.
- R4: Control bits 0..6 are per-source interrupt enables, in the same bit positions as the host-attention bits. host_irq_o is high one cycle after some attention bit and its enable are both set, and low one cycle after no such pair remains.
- R5: A source whose enable is 0 still latches its attention bit, and that bit alone never raises host_irq_o.
- R6: Writing to the chip-attention register sets each bit written as 1 and ignores bits written as 0. Rings are in bits 0..3 and the mailbox is in bit 4. chip_att_o shows the register. chip_kick_o pulses for one cycle on each bit that went from 0 to 1 through that write.
- R7: An acknowledge pulse on chip_ack_i clears its chip-attention bit. A host set of the same bit in the same cycle wins.
- R8: The status register is read-only. Bit 0 is chipset ready, bit 1 is mailbox ready (mbox_rdy_i) and bits 5..2 are err_flags_i. Host writes to it have no effect.
- R9: Control bit 31 is the initialise command. It reads back as 1 for one cycle and then clears itself. While it is set, adapter_init_o is high. At the edge that clears it, both attention registers and the pending kicks clear. chip_ready_o, and status bit 0, are low for exactly 4 cycles starting with the write. The enables are kept.
- R10: After reset, all registers read as zero apart from the status inputs. host_irq_o, chip_att_o, chip_kick_o and adapter_init_o are low, and chip_ready_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr_i | input | 1 | Host write strobe |
| host_rd_i | input | 1 | Host read strobe |
| host_addr_i | input | 2 | Register select |
| host_wdata_i | input | 32 | Host write data |
| host_rdata_o | output | 32 | Registered read data |
| ring_evt_i | input | 4 | Ring event pulses toward host |
| mbox_evt_i | input | 1 | Mailbox event pulse |
| link_evt_i | input | 1 | Link event pulse |
| err_evt_i | input | 1 | Error event pulse |
| mbox_rdy_i | input | 1 | Mailbox ready level |
| err_flags_i | input | 4 | Error condition levels |
| chip_ack_i | input | 5 | Per-request acknowledge pulses |
| host_irq_o | output | 1 | Host interrupt |
| chip_att_o | output | 5 | Pending host requests |
| chip_kick_o | output | 5 | New-request pulses |
| chip_ready_o | output | 1 | Chipset ready |
| adapter_init_o | output | 1 | Initialise command pulse |

## Verification
Attention bits and chip requests change at the edge that samples their pulse or write. Read data and kick pulses show up just after that same edge. host_irq_o lags the attention state by one more edge, and chip_ready_o drops for the four edges after an initialise write. The bench advances a reference state once per rising edge from the inputs it drove before that edge. It compares every output at the following falling edge, so each result is checked in exactly the cycle it is due.

// File: rtl/attn_regs_pkg.sv
// Package: shared register selects and fixed bit positions for the
// attention register block. Assumes a 32-bit host data path.
package attn_regs_pkg;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 2;
    localparam int INIT_BIT = 31;

    typedef enum logic [ADDR_W-1:0] {
        SEL_CTRL = 2'd0,
        SEL_STAT = 2'd1,
        SEL_HATT = 2'd2,
        SEL_CATT = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/hatt_reg.sv
// Host-bound attention register with per-source interrupt masking.
// Each bit is set by an event pulse and cleared by a host write-one.
// An event beats a clear. An init pulse clears everything.
// The interrupt line is registered from the enabled, pending bits.
module hatt_reg #(
    parameter int NUM_SRC = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic               clr_wr_i,
    input  logic [NUM_SRC-1:0] clr_mask_i,
    input  logic               init_i,
    input  logic [NUM_SRC-1:0] en_i,
    output logic [NUM_SRC-1:0] hatt_o,
    output logic               irq_o
);
    logic [NUM_SRC-1:0] pend;
    logic               irq_q;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        logic bit_q;
        // Per-source latch: init, then event, then host clear.
        always_ff @(posedge clk) begin
            if (!rst_n)                         bit_q <= 1'b0;
            else if (init_i)                    bit_q <= 1'b0;
            else if (evt_i[i])                  bit_q <= 1'b1;
            else if (clr_wr_i && clr_mask_i[i]) bit_q <= 1'b0;
        end
        assign hatt_o[i] = bit_q;
        assign pend[i]   = bit_q & en_i[i];
    end

    // Register the OR of enabled pending sources onto the interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |pend;
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/catt_reg.sv
// Chip-bound attention register. The host sets bits with a write-one.
// Internal logic clears them with acknowledge pulses. A set beats an ack.
// A kick pulse marks each bit newly raised by the host. An init pulse
// clears both the bits and the kicks.
module catt_reg #(
    parameter int NUM_CHIP = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                set_wr_i,
    input  logic [NUM_CHIP-1:0] set_mask_i,
    input  logic [NUM_CHIP-1:0] ack_i,
    input  logic                init_i,
    output logic [NUM_CHIP-1:0] catt_o,
    output logic [NUM_CHIP-1:0] kick_o
);
    for (genvar i = 0; i < NUM_CHIP; i++) begin : g_req
        logic req_q;
        logic kick_q;
        logic set_now;

        assign set_now = set_wr_i & set_mask_i[i];

        // Request level: init, then host set, then acknowledge.
        always_ff @(posedge clk) begin
            if (!rst_n)        req_q <= 1'b0;
            else if (init_i)   req_q <= 1'b0;
            else if (set_now)  req_q <= 1'b1;
            else if (ack_i[i]) req_q <= 1'b0;
        end

        // One-cycle kick when a clear request is newly raised.
        always_ff @(posedge clk) begin
            if (!rst_n)      kick_q <= 1'b0;
            else if (init_i) kick_q <= 1'b0;
            else             kick_q <= set_now & ~req_q;
        end

        assign catt_o[i] = req_q;
        assign kick_o[i] = kick_q;
    end
endmodule

// File: rtl/ctrl_stat.sv
// Control and status registers. Control holds the interrupt enables and
// a self-clearing initialise bit. Initialising holds chipset-ready low
// for INIT_CYCLES cycles, counted from the write. Status is assembled
// from the ready state and the live mailbox and error inputs.
module ctrl_stat
    import attn_regs_pkg::*;
#(
    parameter int NUM_SRC     = 7,
    parameter int ERR_W       = 4,
    parameter int INIT_CYCLES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic [NUM_SRC-1:0] en_wdata_i,
    input  logic               init_wdata_i,
    input  logic               mbox_rdy_i,
    input  logic [ERR_W-1:0]   err_i,
    output logic [NUM_SRC-1:0] en_o,
    output logic               init_o,
    output logic               ready_o,
    output logic [DATA_W-1:0]  ctrl_word_o,
    output logic [DATA_W-1:0]  stat_word_o
);
    localparam int CNT_W = $clog2(INIT_CYCLES + 1);

    logic [NUM_SRC-1:0] en_q;
    logic               init_q;
    logic [CNT_W-1:0]   cnt_q;

    // Enables follow host writes to control.
    always_ff @(posedge clk) begin
        if (!rst_n)    en_q <= '0;
        else if (wr_i) en_q <= en_wdata_i;
    end

    // Initialise bit lives for one cycle after it is written.
    always_ff @(posedge clk) begin
        if (!rst_n) init_q <= 1'b0;
        else        init_q <= wr_i & init_wdata_i;
    end

    // Not-ready countdown, loaded by the initialise write.
    always_ff @(posedge clk) begin
        if (!rst_n)                     cnt_q <= '0;
        else if (wr_i && init_wdata_i)  cnt_q <= CNT_W'(INIT_CYCLES);
        else if (cnt_q != '0)           cnt_q <= cnt_q - 1'b1;
    end

    // Assemble the readable words.
    always_comb begin
        ctrl_word_o               = '0;
        ctrl_word_o[NUM_SRC-1:0]  = en_q;
        ctrl_word_o[INIT_BIT]     = init_q;
        stat_word_o               = '0;
        stat_word_o[0]            = ready_o;
        stat_word_o[1]            = mbox_rdy_i;
        stat_word_o[2 +: ERR_W]   = err_i;
    end

    assign en_o    = en_q;
    assign init_o  = init_q;
    assign ready_o = (cnt_q == '0);
endmodule

// File: rtl/adapter_attn_regs.sv
// Top of the attention register block. It decodes host accesses onto the
// four registers, gathers the internal event pulses into the host-bound
// attention vector and returns registered read data. Assumes at most one
// access per cycle. A simultaneous read and write returns the
// pre-write value.
module adapter_attn_regs
    import attn_regs_pkg::*;
#(
    parameter  int NUM_RINGS   = 4,
    parameter  int ERR_W       = 4,
    parameter  int INIT_CYCLES = 4,
    localparam int NUM_SRC     = NUM_RINGS + 3,
    localparam int NUM_CHIP    = NUM_RINGS + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_wr_i,
    input  logic                 host_rd_i,
    input  logic [ADDR_W-1:0]    host_addr_i,
    input  logic [DATA_W-1:0]    host_wdata_i,
    output logic [DATA_W-1:0]    host_rdata_o,
    input  logic [NUM_RINGS-1:0] ring_evt_i,
    input  logic                 mbox_evt_i,
    input  logic                 link_evt_i,
    input  logic                 err_evt_i,
    input  logic                 mbox_rdy_i,
    input  logic [ERR_W-1:0]     err_flags_i,
    input  logic [NUM_CHIP-1:0]  chip_ack_i,
    output logic                 host_irq_o,
    output logic [NUM_CHIP-1:0]  chip_att_o,
    output logic [NUM_CHIP-1:0]  chip_kick_o,
    output logic                 chip_ready_o,
    output logic                 adapter_init_o
);
    reg_sel_e           sel;
    logic               wr_ctrl, wr_hatt, wr_catt;
    logic [NUM_SRC-1:0] evt_vec;
    logic [NUM_SRC-1:0] hatt_q;
    logic [NUM_SRC-1:0] en_q;
    logic [NUM_CHIP-1:0] catt_q;
    logic               init_q;
    logic [DATA_W-1:0]  ctrl_word, stat_word, rd_mux, rdata_q;
    logic               wdata_unused;

    assign sel          = reg_sel_e'(host_addr_i);
    assign wr_ctrl      = host_wr_i && (sel == SEL_CTRL);
    assign wr_hatt      = host_wr_i && (sel == SEL_HATT);
    assign wr_catt      = host_wr_i && (sel == SEL_CATT);
    assign evt_vec      = {err_evt_i, link_evt_i, mbox_evt_i, ring_evt_i};
    assign wdata_unused = ^host_wdata_i[INIT_BIT-1:NUM_SRC];

    ctrl_stat #(
        .NUM_SRC     (NUM_SRC),
        .ERR_W       (ERR_W),
        .INIT_CYCLES (INIT_CYCLES)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_i         (wr_ctrl),
        .en_wdata_i   (host_wdata_i[NUM_SRC-1:0]),
        .init_wdata_i (host_wdata_i[INIT_BIT]),
        .mbox_rdy_i   (mbox_rdy_i),
        .err_i        (err_flags_i),
        .en_o         (en_q),
        .init_o       (init_q),
        .ready_o      (chip_ready_o),
        .ctrl_word_o  (ctrl_word),
        .stat_word_o  (stat_word)
    );

    hatt_reg #(.NUM_SRC(NUM_SRC)) u_hatt (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt_vec),
        .clr_wr_i   (wr_hatt),
        .clr_mask_i (host_wdata_i[NUM_SRC-1:0]),
        .init_i     (init_q),
        .en_i       (en_q),
        .hatt_o     (hatt_q),
        .irq_o      (host_irq_o)
    );

    catt_reg #(.NUM_CHIP(NUM_CHIP)) u_catt (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_wr_i   (wr_catt),
        .set_mask_i (host_wdata_i[NUM_CHIP-1:0]),
        .ack_i      (chip_ack_i),
        .init_i     (init_q),
        .catt_o     (catt_q),
        .kick_o     (chip_kick_o)
    );

    // Select the register addressed by the host.
    always_comb begin
        rd_mux = '0;
        unique case (sel)
            SEL_CTRL: rd_mux = ctrl_word;
            SEL_STAT: rd_mux = stat_word;
            SEL_HATT: rd_mux[NUM_SRC-1:0]  = hatt_q;
            SEL_CATT: rd_mux[NUM_CHIP-1:0] = catt_q;
            default:  rd_mux = '0;
        endcase
    end

    // Capture read data on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)         rdata_q <= '0;
        else if (host_rd_i) rdata_q <= rd_mux;
    end

    assign host_rdata_o   = rdata_q;
    assign chip_att_o     = catt_q;
    assign adapter_init_o = init_q;
endmodule

// File: rtl/adapter_attn_regs_chk.sv
// Checker bound to the top. Its properties cover event latching,
// interrupt origin, request retirement, kick consistency and the
// effect of initialisation.
module adapter_attn_regs_chk #(
    parameter int NUM_SRC  = 7,
    parameter int NUM_CHIP = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_SRC-1:0]  evt_vec,
    input logic [NUM_SRC-1:0]  hatt_q,
    input logic [NUM_SRC-1:0]  en_q,
    input logic                init_q,
    input logic                host_irq_o,
    input logic [NUM_CHIP-1:0] chip_att_o,
    input logic [NUM_CHIP-1:0] chip_kick_o,
    input logic [NUM_CHIP-1:0] chip_ack_i,
    input logic                chip_ready_o
);
    AST_EVT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        !init_q |=> ((hatt_q & $past(evt_vec)) == $past(evt_vec))); // R3

    AST_IRQ_FROM_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq_o |-> $past(|(hatt_q & en_q))); // R4

    AST_REQ_DROPS_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($past(init_q) || ((~chip_att_o & $past(chip_att_o) & ~$past(chip_ack_i)) == '0))); // R7

    AST_KICK_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_kick_o & ~chip_att_o) == '0); // R6

    AST_INIT_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
        init_q |=> (hatt_q == '0 && chip_att_o == '0 && !init_q)); // R9

    AST_INIT_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        init_q |-> !chip_ready_o); // R9
endmodule

bind adapter_attn_regs adapter_attn_regs_chk #(
    .NUM_SRC  (NUM_SRC),
    .NUM_CHIP (NUM_CHIP)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .evt_vec      (evt_vec),
    .hatt_q       (hatt_q),
    .en_q         (en_q),
    .init_q       (init_q),
    .host_irq_o   (host_irq_o),
    .chip_att_o   (chip_att_o),
    .chip_kick_o  (chip_kick_o),
    .chip_ack_i   (chip_ack_i),
    .chip_ready_o (chip_ready_o)
);

// File: tb/tb_adapter_attn_regs.sv
`timescale 1ns/1ps
module tb_adapter_attn_regs;
    localparam int NR = 4, NS = 7, NC = 5, EW = 4, IC = 4;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst_n, wr, rd, mbox_evt, link_evt, err_evt, mbox_rdy;
    logic [1:0]    addr;
    logic [31:0]   wdata, rdata;
    logic [NR-1:0] ring_evt;
    logic [EW-1:0] err_flags;
    logic [NC-1:0] ack, att, kick;
    logic          irq, ready, init;

    adapter_attn_regs dut (
        .clk(clk), .rst_n(rst_n), .host_wr_i(wr), .host_rd_i(rd),
        .host_addr_i(addr), .host_wdata_i(wdata), .host_rdata_o(rdata),
        .ring_evt_i(ring_evt), .mbox_evt_i(mbox_evt), .link_evt_i(link_evt),
        .err_evt_i(err_evt), .mbox_rdy_i(mbox_rdy), .err_flags_i(err_flags),
        .chip_ack_i(ack), .host_irq_o(irq), .chip_att_o(att),
        .chip_kick_o(kick), .chip_ready_o(ready), .adapter_init_o(init)
    );

    // Reference state, advanced once per rising edge.
    logic [NS-1:0] m_hatt, m_en;
    logic [NC-1:0] m_catt, m_kick;
    logic          m_init, m_irq;
    int            m_cnt;
    logic [31:0]   m_rdata;
    int            n_cmp = 0, n_bad = 0;
    string         cur_tag = "R10";
    bit            done = 0;

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", cur_tag, what, act, exp);
        end
    endtask

    // Register contents the host would read right now.
    function automatic logic [31:0] f_read();
        logic [31:0] r = '0;
        case (addr)
            2'd0: begin r[NS-1:0] = m_en; r[31] = m_init; end
            2'd1: begin r[0] = (m_cnt == 0); r[1] = mbox_rdy; r[5:2] = err_flags; end
            2'd2: r[NS-1:0] = m_hatt;
            default: r[NC-1:0] = m_catt;
        endcase
        return r;
    endfunction

    // One clock: predict, take the edge, compare at the falling edge.
    task automatic cycle();
        logic [NS-1:0] evt, hn;
        logic [NC-1:0] setm, cn, kn;
        logic [NS-1:0] en_n;
        logic          in_n, irq_n;
        int            cnt_n;
        logic [31:0]   rd_n;
        evt   = {err_evt, link_evt, mbox_evt, ring_evt};
        rd_n  = rd ? f_read() : m_rdata;
        hn    = m_hatt | evt;
        if (wr && addr == 2'd2) hn = (m_hatt & ~wdata[NS-1:0]) | evt;
        if (m_init) hn = '0;
        setm  = (wr && addr == 2'd3) ? wdata[NC-1:0] : '0;
        cn    = m_init ? '0 : ((m_catt & ~ack) | setm);
        kn    = m_init ? '0 : (setm & ~m_catt);
        en_n  = (wr && addr == 2'd0) ? wdata[NS-1:0] : m_en;
        in_n  = wr && addr == 2'd0 && wdata[31];
        cnt_n = in_n ? IC : (m_cnt > 0 ? m_cnt - 1 : 0);
        irq_n = |(m_hatt & m_en);
        @(posedge clk);
        m_hatt = hn; m_catt = cn; m_kick = kn; m_en = en_n;
        m_init = in_n; m_cnt = cnt_n; m_irq = irq_n; m_rdata = rd_n;
        @(negedge clk);
        chk("irq",   {31'b0, irq},   {31'b0, m_irq});
        chk("ready", {31'b0, ready}, {31'b0, m_cnt == 0});
        chk("init",  {31'b0, init},  {31'b0, m_init});
        chk("att",   {27'b0, att},   {27'b0, m_catt});
        chk("kick",  {27'b0, kick},  {27'b0, m_kick});
        chk("rdata", rdata, m_rdata);
    endtask

    task automatic idle();
        wr = 0; rd = 0; addr = 0; wdata = 0; ring_evt = 0;
        mbox_evt = 0; link_evt = 0; err_evt = 0; ack = 0;
    endtask

    task automatic wr_reg(logic [1:0] a, logic [31:0] d);
        wr = 1; addr = a; wdata = d; cycle(); wr = 0; wdata = 0;
    endtask

    task automatic rd_reg(logic [1:0] a);
        rd = 1; addr = a; cycle(); rd = 0;
    endtask

    task automatic pulse_src(int i);
        if (i < NR) ring_evt[i] = 1'b1;
        else if (i == 4) mbox_evt = 1'b1;
        else if (i == 5) link_evt = 1'b1;
        else err_evt = 1'b1;
    endtask

    // Watchdog: an expired run counts as a failure and still summarises.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        idle(); mbox_rdy = 1; err_flags = 4'hA; rst_n = 0;
        m_hatt = 0; m_en = 0; m_catt = 0; m_kick = 0; m_init = 0;
        m_irq = 0; m_cnt = 0; m_rdata = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R10: reset state on every output and register.
        cur_tag = "R10";
        cycle();
        for (int a = 0; a < 4; a++) rd_reg(2'(a));

        // R2: each source sets its own bit and nothing else.
        cur_tag = "R2";
        for (int i = 0; i < NS; i++) begin
            pulse_src(i); cycle(); idle();
            rd_reg(2'd2);
            chk("single bit", rdata, 32'(1) << i);
            wr_reg(2'd2, 32'(1) << i);
        end

        // R3: write-one-to-clear, event beats clear.
        cur_tag = "R3";
        ring_evt = 4'hF; mbox_evt = 1; cycle(); idle();
        ring_evt[1] = 1'b1; wr_reg(2'd2, 32'h7F); idle();
        rd_reg(2'd2);
        chk("event wins", rdata, 32'h02);

        // R5: masked bit stays visible, no interrupt.
        cur_tag = "R5";
        repeat (3) cycle();
        chk("masked irq", {31'b0, irq}, 32'h0);

        // R4: enable the pending source, interrupt follows.
        cur_tag = "R4";
        wr_reg(2'd0, 32'h02);
        cycle();
        chk("irq up", {31'b0, irq}, 32'h1);
        wr_reg(2'd2, 32'h02); cycle();
        chk("irq down", {31'b0, irq}, 32'h0);

        // R6: host sets requests, zeros ignored, kick on new bits only.
        cur_tag = "R6";
        wr_reg(2'd3, 32'h05);
        wr_reg(2'd3, 32'h00);
        wr_reg(2'd3, 32'h07);
        chk("kick new only", {27'b0, kick}, 32'h02);
        rd_reg(2'd3);

        // R7: acknowledge clears, simultaneous set wins.
        cur_tag = "R7";
        ack = 5'h01; cycle(); idle();
        ack = 5'h02; wr_reg(2'd3, 32'h02); idle();
        chk("set beats ack", {27'b0, att}, 32'h06);

        // R8: status is read-only and reflects inputs.
        cur_tag = "R8";
        wr_reg(2'd1, 32'hFFFF_FFFF);
        mbox_rdy = 0; err_flags = 4'h5; rd_reg(2'd1);
        chk("status", rdata, 32'h14 | 32'h1);

        // R9: initialise wipes attention and drops ready for four cycles.
        cur_tag = "R9";
        ring_evt = 4'h9; cycle(); idle();
        wr_reg(2'd0, 32'h8000_007F);
        chk("init seen", {31'b0, init}, 32'h1);
        cycle();
        chk("init self clear", {31'b0, init}, 32'h0);
        repeat (4) cycle();
        rd_reg(2'd0);
        chk("enables kept", rdata, 32'h7F);

        // R1: random traffic over every register.
        cur_tag = "R1";
        for (int n = 0; n < 4000; n++) begin
            idle();
            mbox_rdy  = 1'($urandom);
            err_flags = 4'($urandom);
            ring_evt  = 4'($urandom) & 4'($urandom);
            mbox_evt  = ($urandom % 5) == 0;
            link_evt  = ($urandom % 7) == 0;
            err_evt   = ($urandom % 9) == 0;
            ack       = 5'($urandom) & 5'($urandom);
            addr      = 2'($urandom);
            rd        = ($urandom % 2) == 0;
            wr        = ($urandom % 4) == 0;
            wdata     = $urandom;
            if (($urandom % 16) != 0) wdata[31] = 1'b0;
            cycle();
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule